// File: doc/BRIEF.md
# Change-History Plateau Detector

This block watches a stream of converter samples that arrive with a valid strobe. It decides when a stepped input has come to rest and reports the level it rests at. For each valid sample it compares the sample with the one before it. If the absolute difference is larger than a programmable noise margin, it records a change bit. These bits are shifted into a history register whose active length is set at run time. The input counts as settled only once every active history bit is clear. At that point the current sample is reported as the plateau level, with a one-cycle strobe.

A small state machine sequences the reporting through three states. `ST_PRIME` is the state after reset, before any reference sample is held. `ST_TRACK` means the history still holds at least one change. `ST_SETTLED` means a plateau has already been reported. The named transitions are:

- *first_sample*: `ST_PRIME` → `ST_TRACK`, on the first valid sample.
- *settle*: `ST_TRACK` → `ST_SETTLED`, on a sample that leaves the history clear. This transition also emits the report.
- *disturb*: `ST_SETTLED` → `ST_TRACK`, on a sample that leaves the history non-zero.
- *hold*: a valid sample that keeps the state as it is. This applies to tracking that continues and to a plateau that continues.

Cycles without a valid sample never change the state.

Top module: `plateau_detector`

## Requirements
- R1: The history, the reference sample and the state change only on cycles with `smp_valid_i` high. Idle cycles neither advance the window nor produce a report.
- R2: A sample is marked changed only when the magnitude of its difference from the reference is strictly greater than `margin_i`. This applies to rising and falling steps alike. The magnitude is computed one bit wider than the sample, so a full-scale swing never wraps.
- R3: The reference sample is replaced by every valid sample, whether or not that sample was marked changed. A slow drift in steps no larger than the margin therefore counts as unchanged.
- R4: The window length is `win_len_i` samples, from 1 to 16. A value of 0 acts as 1, and a value above 16 acts as 16.
- R5: When a valid sample leaves the active history entirely clear while tracking, `lvl_valid_o` is high for exactly one cycle. That cycle follows the clock edge at which the sample was taken, and `lvl_data_o` then equals that sample. `lvl_data_o` holds its value between reports.
- R6: A plateau is reported only once. Later unchanged samples produce no further report until a change has been recorded.
- R7: After reset, both outputs are zero and the history is all ones. The first sample after reset serves only as the reference. A report then needs `win_len` further unchanged samples.
- R8: Once settled, a single changed sample restarts tracking. A new report then follows after `win_len` unchanged samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Unsigned sample value |
| margin_i | input | 12 | Noise margin; a difference must exceed it to count as a change |
| win_len_i | input | 5 | Active history length in samples |
| lvl_valid_o | output | 1 | One-cycle plateau report strobe |
| lvl_data_o | output | 12 | Last reported plateau level |

## Verification
The assertions assume that `margin_i` and `win_len_i` stay constant during a run of samples. They are changed only while reset is asserted. The assertions also assume that samples may arrive on back-to-back cycles or with idle gaps of any length. Under those assumptions, a report can never be followed by a second report on the next cycle, and every strobe matches the sample taken one edge earlier. The stimulus follows these rules: each scenario sets the margin and window under reset before sending samples, and it mixes consecutive samples with idle gaps.

// File: rtl/plateau_pkg.sv
`timescale 1ns/1ps
package plateau_pkg;

    typedef enum logic [1:0] {
        ST_PRIME   = 2'd0,
        ST_TRACK   = 2'd1,
        ST_SETTLED = 2'd2
    } pd_state_e;

endpackage

// File: rtl/pd_change_cmp.sv
`timescale 1ns/1ps
module pd_change_cmp #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic [SAMPLE_W-1:0] margin_i,
    input  logic                force_chg_i,
    output logic                chg_flag_o
);
    localparam int DW = SAMPLE_W + 1;

    logic [SAMPLE_W-1:0] ref_q;
    logic [DW-1:0]       delta;
    logic [DW-1:0]       mag;

    always_comb begin
        delta = {1'b0, smp_data_i} - {1'b0, ref_q};
        mag   = delta[DW-1] ? (~delta + 1'b1) : delta;
        chg_flag_o = force_chg_i || (mag > {1'b0, margin_i});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_q <= '0;
        end else if (smp_valid_i) begin
            ref_q <= smp_data_i;
        end
    end

    // R3: the reference follows every valid sample
    p_ref_tracks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i |=> ref_q == $past(smp_data_i));

    // R1: the reference is untouched on idle cycles
    p_ref_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !smp_valid_i |=> $stable(ref_q));

endmodule

// File: rtl/pd_history.sv
`timescale 1ns/1ps
module pd_history #(
    parameter int HIST_MAX = 16,
    parameter int LEN_W    = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                shift_en_i,
    input  logic                flag_i,
    input  logic [LEN_W-1:0]    win_len_i,
    output logic [HIST_MAX-1:0] hist_next_o,
    output logic                hist_zero_o
);
    logic [HIST_MAX-1:0] hist_q;
    logic [HIST_MAX-1:0] mask;
    logic [LEN_W-1:0]    eff_len;

    always_comb begin
        if (win_len_i == '0) begin
            eff_len = LEN_W'(1);
        end else if (int'(win_len_i) > HIST_MAX) begin
            eff_len = LEN_W'(HIST_MAX);
        end else begin
            eff_len = win_len_i;
        end
    end

    for (genvar gi = 0; gi < HIST_MAX; gi++) begin : g_mask
        assign mask[gi] = (gi < int'(eff_len));
    end

    always_comb begin
        hist_next_o = ({hist_q[HIST_MAX-2:0], 1'b0} | {{(HIST_MAX-1){1'b0}}, flag_i}) & mask;
        hist_zero_o = (hist_next_o == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '1;
        end else if (shift_en_i) begin
            hist_q <= hist_next_o;
        end
    end

    // R1: no shift without a sample
    p_hist_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_en_i |=> $stable(hist_q));

    // R2: a flagged sample always leaves bit 0 set
    p_flag_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_en_i && flag_i) |=> hist_q[0]);

endmodule

// File: rtl/pd_fsm.sv
`timescale 1ns/1ps
module pd_fsm
    import plateau_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic smp_valid_i,
    input  logic hist_zero_i,
    output logic force_chg_o,
    output logic report_o
);
    pd_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (smp_valid_i) begin
            unique case (state_q)
                ST_PRIME:   state_d = ST_TRACK;
                ST_TRACK:   state_d = hist_zero_i ? ST_SETTLED : ST_TRACK;
                ST_SETTLED: state_d = hist_zero_i ? ST_SETTLED : ST_TRACK;
                default:    state_d = ST_PRIME;
            endcase
        end
    end

    always_comb begin
        force_chg_o = (state_q == ST_PRIME);
        report_o    = smp_valid_i && (state_q == ST_TRACK) && hist_zero_i;
    end

    // R7: nothing is reported before a reference sample exists
    p_prime_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PRIME) |-> !report_o);

    // R6: a report is always followed by the settled state
    p_report_settles_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        report_o |=> state_q == ST_SETTLED);

endmodule

// File: rtl/plateau_detector.sv
`timescale 1ns/1ps
module plateau_detector #(
    parameter int SAMPLE_W = 12,
    parameter int HIST_MAX = 16,
    localparam int LEN_W   = $clog2(HIST_MAX + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic [SAMPLE_W-1:0] margin_i,
    input  logic [LEN_W-1:0]    win_len_i,
    output logic                lvl_valid_o,
    output logic [SAMPLE_W-1:0] lvl_data_o
);
    logic                chg_flag;
    logic                force_chg;
    logic                hist_zero;
    logic                report;
    logic [HIST_MAX-1:0] hist_next;

    pd_change_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .smp_valid_i(smp_valid_i),
        .smp_data_i (smp_data_i),
        .margin_i   (margin_i),
        .force_chg_i(force_chg),
        .chg_flag_o (chg_flag)
    );

    pd_history #(.HIST_MAX(HIST_MAX), .LEN_W(LEN_W)) u_hist (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shift_en_i (smp_valid_i),
        .flag_i     (chg_flag),
        .win_len_i  (win_len_i),
        .hist_next_o(hist_next),
        .hist_zero_o(hist_zero)
    );

    pd_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .smp_valid_i(smp_valid_i),
        .hist_zero_i(hist_zero),
        .force_chg_o(force_chg),
        .report_o   (report)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_valid_o <= 1'b0;
            lvl_data_o  <= '0;
        end else begin
            lvl_valid_o <= report;
            if (report) begin
                lvl_data_o <= smp_data_i;
            end
        end
    end

    // R5: a report carries the sample taken one edge earlier
    p_level_matches_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_valid_o |-> (lvl_data_o == $past(smp_data_i)) && $past(smp_valid_i));

    // R6: the strobe never lasts two cycles
    p_one_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_valid_o |=> !lvl_valid_o);

    // R5: the level holds between reports
    p_level_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lvl_valid_o |-> $stable(lvl_data_o));

endmodule

// File: tb/plateau_detector_bench.sv
`timescale 1ns/1ps
module plateau_detector_bench;
    localparam int SW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [SW-1:0] margin = '0;
    logic [4:0]    win_len = 5'd8;
    logic          lvl_valid;
    logic [SW-1:0] lvl_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    bit  m_have_ref;
    int  m_ref;
    int  m_quiet;
    int  m_last_lvl;

    always #10 clk = ~clk;

    plateau_detector u_plateau_detector (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .smp_valid_i(smp_valid),
        .smp_data_i (smp_data),
        .margin_i   (margin),
        .win_len_i  (win_len),
        .lvl_valid_o(lvl_valid),
        .lvl_data_o (lvl_data)
    );

    function automatic int eff_len();
        if (win_len == 0) return 1;
        if (win_len > 16) return 16;
        return int'(win_len);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int mg, input int wl);
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        margin = SW'(mg);
        win_len = 5'(wl);
        m_have_ref = 1'b0;
        m_ref = 0;
        m_quiet = 0;
        m_last_lvl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R7 reset valid", int'(lvl_valid), 0);
        check("R7 reset data", int'(lvl_data), 0);
    endtask

    // send one sample, check the registered report one edge later
    task automatic send(input int v, input string req);
        bit chg;
        int d;
        bit exp_v;
        smp_valid = 1'b1;
        smp_data = SW'(v);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        d = v - m_ref;
        if (d < 0) d = -d;
        chg = !m_have_ref || (d > int'(margin));
        m_have_ref = 1'b1;
        m_ref = v;
        m_quiet = chg ? 0 : m_quiet + 1;
        exp_v = (m_quiet == eff_len());
        if (exp_v) m_last_lvl = v;
        check(req, int'(lvl_valid), int'(exp_v));
        check(req, int'(lvl_data), m_last_lvl);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, int'(lvl_valid), 0);
        end
    endtask

    task automatic t_staircase();
        do_reset(5, 8);
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 11; k++) send(100 + s * 300, "R5 R6 R7 staircase");
        end
    endtask

    task automatic t_margin_edge();
        do_reset(10, 4);
        send(500, "R2 ref");
        for (int k = 0; k < 3; k++) send(500, "R2 quiet");
        send(510, "R2 equal margin not a change");
        send(510, "R2 settled");
        send(521, "R2 margin+1 is a change");
        for (int k = 0; k < 5; k++) send(521, "R8 resettle");
        send(510, "R2 falling change");
        for (int k = 0; k < 5; k++) send(510, "R2 falling resettle");
    endtask

    task automatic t_idle_gaps();
        do_reset(2, 5);
        send(40, "R1 ref");
        for (int k = 0; k < 6; k++) begin
            idle(3, "R1 gap silent");
            send(40, "R1 gapped samples");
        end
    endtask

    task automatic t_drift();
        do_reset(4, 6);
        for (int k = 0; k < 10; k++) send(1000 + 4 * k, "R3 drift within margin");
    endtask

    task automatic t_lengths();
        do_reset(0, 3);
        send(7, "R4 len3");
        for (int k = 0; k < 4; k++) send(7, "R4 len3");
        do_reset(0, 0);
        send(9, "R4 len0 acts as 1");
        send(9, "R4 len0 acts as 1");
        send(9, "R6 len1 no repeat");
        send(12, "R8 len1 change");
        send(12, "R8 len1 resettle");
        do_reset(0, 20);
        send(33, "R4 len20 acts as 16");
        for (int k = 0; k < 18; k++) send(33, "R4 len20 acts as 16");
        do_reset(0, 16);
        send(44, "R4 len16");
        for (int k = 0; k < 17; k++) send(44, "R4 len16");
    endtask

    task automatic t_full_swing();
        do_reset(4094, 2);
        send(0, "R2 swing ref");
        send(4095, "R2 full rise flagged");
        send(4095, "R2 hold");
        send(4095, "R2 hold");
        send(0, "R2 full fall flagged");
        send(1, "R2 small");
        send(1, "R2 small");
        send(1, "R2 small");
    endtask

    initial begin
        t_staircase();
        t_margin_edge();
        t_idle_gaps();
        t_drift();
        t_lengths();
        t_full_swing();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule